// File: doc/BRIEF.md
# Serial Configuration Load and Readback Port

This block is a five-wire serial port that writes and reads back the configuration store of a small programmable logic array. An external master drives an active-low enable, a serial clock, a serial data input and a mode pin, and it receives one serial data output. Behind the port sit three things:

- a row-select shift register, where each bit enables one row of the store;
- a data shift register built from two equal halves that are chained together;
- a behavioural configuration store with one row per row-select bit.

A control sequencer reads a 4-bit command from the pins and then does one of five things: shift the row-select register, shift the data register, program rows, verify a row, or load the fixed identifier. The identifier can then be shifted out.

When the enable pin is high the port is idle. The same pins then serve the user logic: the data-in, data-out and mode pins act as ordinary inputs, and the serial clock acts as a user clock. The port has no stream data path. Every pin is a plain level or clock, so there is no valid/ready handshake and no back-pressure. The master paces all transfers with the serial clock.

All port state changes on the rising edge of the serial clock. The serial output changes on the falling edge, so the master can sample it on the next rising edge. The configuration store has no reset, which models non-volatile contents.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, with the enable high, the serial output and the error flag are 0.
- R2: With `en_n` high, `usr_in` equals {`mode`, `sdo_in`, `sdi`}. `usr_clk` follows `sclk`. `sdo_oe` and `sdo` are 0. With `en_n` low, `usr_in` and `usr_clk` are held at 0 and `sdo_oe` is 1.
- R3: The command sequence runs on `sclk` rising edges, in this order:
  - From idle, an edge with mode high opens command entry.
  - Each edge with mode low shifts `sdi` into a 4-bit command, most significant bit first.
  - The next mode-high edge latches the command.
  - The mode-high edge after that executes it.
  - The codes are 1 (shift row-select), 2 (shift data), 3 (program), 4 (verify) and 5 (identifier).
- R4: In a shift state, each mode-low edge moves `sdi` into the top bit of the selected register and shifts that register one place toward bit 0. The data register's upper half feeds its lower half. `sdo` shows bit 0 of the selected register after each falling edge. After a shift, a mode-high edge opens command entry again.
- R5: Program writes the 160-bit data register into every row whose row-select bit is 1.
- R6: Verify with exactly one row-select bit set loads that row into the data register and clears the error flag. With no bit set, it loads zeros and clears the error flag.
- R7: Verify with more than one row-select bit set loads zeros and sets the error flag.
- R8: The identifier command loads 0x0B into data bits 7..0 and zeros into the rest, then enters the data shift state. The identifier therefore leaves least significant bit first.
- R9: Raising `en_n` aborts any command in progress and returns the sequencer to idle. The stored rows are left unchanged.
- R10: Stored rows survive an assertion of `rst_n`.
- R11: A command code outside 1..5 changes neither register and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; the user clock when the port is disabled |
| rst_n | input | 1 | Active-low asynchronous reset of the port logic (not the store) |
| en_n | input | 1 | Active-low port enable |
| sdi | input | 1 | Serial data and command input |
| mode | input | 1 | Sequencer control: high = step, low = shift |
| sdo_in | input | 1 | Level on the shared data-out pin, used when the port is disabled |
| sdo | output | 1 | Serial data output, changes on the falling edge |
| sdo_oe | output | 1 | Drive enable for the data-out pin |
| usr_in | output | 3 | User inputs {mode, sdo_in, sdi} when the port is disabled |
| usr_clk | output | 1 | User clock, gated off while the port is enabled |
| err | output | 1 | Set by a verify that selects several rows |

## Verification
The store is exercised with several kinds of row-select pattern, each checked against a reference model in the bench:
- Random single rows with random 160-bit data check that the right row is written and read. They also check that both data halves chain in the right order.
- A two-row program shows that a program writes every selected row.
- A multi-row verify and an empty-select verify separate the error case from the all-zero case.

Directed sequences cover four further cases:
- an aborted program, which must leave the store unchanged;
- a port reset, which must not clear the stored rows;
- an unknown command code, which must change neither register;
- the identifier read-out, whose bit order is checked.

// File: rtl/cfg_port_pkg.sv
`timescale 1ns/1ps
package cfg_port_pkg;
  localparam int CMD_W = 4;
  localparam logic [7:0] CFG_ID = 8'h0B;

  localparam logic [CMD_W-1:0] OP_ADDR   = 4'h1;
  localparam logic [CMD_W-1:0] OP_DATA   = 4'h2;
  localparam logic [CMD_W-1:0] OP_PROG   = 4'h3;
  localparam logic [CMD_W-1:0] OP_VERIFY = 4'h4;
  localparam logic [CMD_W-1:0] OP_ID     = 4'h5;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_EXEC  = 2'd2,
    ST_SHIFT = 2'd3
  } cfg_state_e;
endpackage

// File: rtl/cfg_shreg.sv
`timescale 1ns/1ps
module cfg_shreg #(
  parameter int W = 80
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         sin,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] q
);
  // Serial data enters at the top bit and leaves from bit 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load_en)  q <= load_val;
    else if (shift_en) q <= {sin, q[W-1:1]};
  end
endmodule

// File: rtl/cfg_seq.sv
`timescale 1ns/1ps
module cfg_seq
  import cfg_port_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_n,
  input  logic mode,
  input  logic sdi,
  output logic addr_shift,
  output logic data_shift,
  output logic sel_addr,
  output logic do_prog,
  output logic do_verify,
  output logic do_id
);
  cfg_state_e       state;
  logic [CMD_W-1:0] cmd;
  logic             act;

  assign act = !en_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cmd   <= '0;
    end else if (!act) begin
      state <= ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: if (mode) begin
          state <= ST_CMD;
          cmd   <= '0;
        end
        ST_CMD: begin
          if (mode) state <= ST_EXEC;
          else      cmd   <= {cmd[CMD_W-2:0], sdi};
        end
        ST_EXEC: if (mode) begin
          if (cmd == OP_ADDR || cmd == OP_DATA || cmd == OP_ID) state <= ST_SHIFT;
          else                                                   state <= ST_IDLE;
        end
        ST_SHIFT: if (mode) begin
          state <= ST_CMD;
          cmd   <= '0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic exec_edge, shift_edge;
  assign exec_edge  = act && mode && (state == ST_EXEC);
  assign shift_edge = act && !mode && (state == ST_SHIFT);

  assign sel_addr   = (state == ST_SHIFT) && (cmd == OP_ADDR);
  assign addr_shift = shift_edge && (cmd == OP_ADDR);
  assign data_shift = shift_edge && (cmd == OP_DATA || cmd == OP_ID);
  assign do_prog    = exec_edge && (cmd == OP_PROG);
  assign do_verify  = exec_edge && (cmd == OP_VERIFY);
  assign do_id      = exec_edge && (cmd == OP_ID);

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_shift, data_shift, do_prog, do_verify, do_id}));  // R3
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |=> (state == ST_IDLE));  // R9
  AST_CMD_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (act && mode && state == ST_IDLE) |=> (state == ST_CMD && cmd == '0));  // R3
endmodule

// File: rtl/cfg_rows.sv
`timescale 1ns/1ps
module cfg_rows #(
  parameter int ROWS = 110,
  parameter int DW   = 160
) (
  input  logic            clk,
  input  logic            prog,
  input  logic [ROWS-1:0] sel,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            multi
);
  // Behavioural non-volatile store: deliberately without reset.
  logic [DW-1:0] mem [ROWS];

  always_ff @(posedge clk) begin
    for (int r = 0; r < ROWS; r++) begin
      if (prog && sel[r]) mem[r] <= wdata;
    end
  end

  logic [DW-1:0] acc;
  assign multi = |(sel & (sel - {{(ROWS-1){1'b0}}, 1'b1}));

  always_comb begin
    acc = '0;
    for (int r = 0; r < ROWS; r++) begin
      if (sel[r]) acc = acc | mem[r];
    end
  end

  assign rdata = multi ? '0 : acc;
endmodule

// File: rtl/cfg_serial_port.sv
`timescale 1ns/1ps
module cfg_serial_port
  import cfg_port_pkg::*;
#(
  parameter int ROWS = 110,
  parameter int DW   = 160
) (
  input  logic       sclk,
  input  logic       rst_n,
  input  logic       en_n,
  input  logic       sdi,
  input  logic       mode,
  input  logic       sdo_in,
  output logic       sdo,
  output logic       sdo_oe,
  output logic [2:0] usr_in,
  output logic       usr_clk,
  output logic       err
);
  localparam int NH   = 2;
  localparam int HALF = DW / NH;

  logic addr_shift, data_shift, sel_addr, do_prog, do_verify, do_id;
  logic [ROWS-1:0] addr_q;
  logic [DW-1:0]   data_q, rd_data, load_val;
  logic            multi;
  logic [NH-1:0]   half_in;

  cfg_seq u_seq (
    .clk(sclk), .rst_n(rst_n), .en_n(en_n), .mode(mode), .sdi(sdi),
    .addr_shift(addr_shift), .data_shift(data_shift), .sel_addr(sel_addr),
    .do_prog(do_prog), .do_verify(do_verify), .do_id(do_id)
  );

  cfg_shreg #(.W(ROWS)) u_addr (
    .clk(sclk), .rst_n(rst_n), .shift_en(addr_shift), .sin(sdi),
    .load_en(1'b0), .load_val('0), .q(addr_q)
  );

  assign load_val = do_id ? {{(DW-8){1'b0}}, CFG_ID} : rd_data;

  // Data register halves: the top half takes sdi, each lower half takes
  // bit 0 of the half above it.
  for (genvar h = 0; h < NH; h++) begin : g_half
    if (h == NH - 1) begin : g_top
      assign half_in[h] = sdi;
    end else begin : g_chain
      assign half_in[h] = data_q[(h+1)*HALF];
    end
    cfg_shreg #(.W(HALF)) u_half (
      .clk(sclk), .rst_n(rst_n), .shift_en(data_shift), .sin(half_in[h]),
      .load_en(do_verify || do_id), .load_val(load_val[h*HALF +: HALF]),
      .q(data_q[h*HALF +: HALF])
    );
  end

  cfg_rows #(.ROWS(ROWS), .DW(DW)) u_rows (
    .clk(sclk), .prog(do_prog), .sel(addr_q), .wdata(data_q),
    .rdata(rd_data), .multi(multi)
  );

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)         err <= 1'b0;
    else if (do_verify) err <= multi;
  end

  // Output changes on the falling edge, ready for the master's next rising edge.
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n)    sdo <= 1'b0;
    else if (en_n) sdo <= 1'b0;
    else           sdo <= sel_addr ? addr_q[0] : data_q[0];
  end

  assign sdo_oe  = !en_n;
  assign usr_in  = en_n ? {mode, sdo_in, sdi} : 3'b000;
  assign usr_clk = sclk & en_n;

  AST_VERIFY_MULTI: assert property (@(posedge sclk) disable iff (!rst_n)
    (do_verify && multi) |=> (err && data_q == '0));  // R7
  AST_VERIFY_SINGLE: assert property (@(posedge sclk) disable iff (!rst_n)
    (do_verify && !multi) |=> !err);  // R6
  AST_ID_LOAD: assert property (@(posedge sclk) disable iff (!rst_n)
    do_id |=> (data_q[7:0] == CFG_ID));  // R8
  AST_PIN_QUIET: assert property (@(posedge sclk) disable iff (!rst_n)
    (en_n && $past(en_n)) |-> !sdo);  // R2
  AST_NO_EXEC_OFF: assert property (@(posedge sclk) disable iff (!rst_n)
    en_n |-> !(do_prog || do_verify || do_id || addr_shift || data_shift));  // R9
endmodule

// File: tb/sim_cfg_serial_port.sv
`timescale 1ns/1ps
module sim_cfg_serial_port;
  localparam int ROWS = 110;
  localparam int DW   = 160;

  logic sclk = 0, rst_n = 0, en_n = 1, sdi = 0, mode = 0, sdo_in = 0;
  logic sdo, sdo_oe, usr_clk, err;
  logic [2:0] usr_in;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [DW-1:0] model [ROWS];
  bit            written [ROWS];

  always #10 sclk = ~sclk;

  cfg_serial_port #(.ROWS(ROWS), .DW(DW)) u0 (
    .sclk(sclk), .rst_n(rst_n), .en_n(en_n), .sdi(sdi), .mode(mode),
    .sdo_in(sdo_in), .sdo(sdo), .sdo_oe(sdo_oe), .usr_in(usr_in),
    .usr_clk(usr_clk), .err(err)
  );

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic edge_step(input logic m, input logic d);
    mode = m; sdi = d;
    @(posedge sclk); #1;
  endtask

  task automatic send_cmd(input logic [3:0] c);
    edge_step(1'b1, 1'b0);
    for (int i = 3; i >= 0; i--) edge_step(1'b0, c[i]);
    edge_step(1'b1, 1'b0);
    edge_step(1'b1, 1'b0);
  endtask

  task automatic shift_io(input int n, input logic [DW-1:0] din, output logic [DW-1:0] dout);
    dout = '0;
    for (int i = 0; i < n; i++) begin
      @(negedge sclk); #1;
      dout[i] = sdo;
      mode = 1'b0; sdi = din[i];
      @(posedge sclk); #1;
    end
  endtask

  function automatic logic [DW-1:0] widen(input logic [ROWS-1:0] a);
    logic [DW-1:0] t = '0;
    t[ROWS-1:0] = a;
    return t;
  endfunction

  function automatic logic [DW-1:0] exp_verify(input logic [ROWS-1:0] a);
    logic [DW-1:0] acc = '0;
    if ($countones(a) > 1) return '0;
    for (int r = 0; r < ROWS; r++) if (a[r]) acc = acc | model[r];
    return acc;
  endfunction

  function automatic logic [DW-1:0] rand_word();
    logic [DW-1:0] v = '0;
    for (int i = 0; i < DW / 32; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic load_addr(input logic [ROWS-1:0] a);
    logic [DW-1:0] junk;
    send_cmd(4'h1);
    shift_io(ROWS, widen(a), junk);
  endtask

  task automatic load_data(input logic [DW-1:0] d);
    logic [DW-1:0] junk;
    send_cmd(4'h2);
    shift_io(DW, d, junk);
  endtask

  task automatic read_data(output logic [DW-1:0] d);
    send_cmd(4'h2);
    shift_io(DW, '0, d);
  endtask

  task automatic program_rows(input logic [ROWS-1:0] a, input logic [DW-1:0] d);
    load_addr(a);
    load_data(d);
    send_cmd(4'h3);
    for (int r = 0; r < ROWS; r++) if (a[r]) begin model[r] = d; written[r] = 1; end
  endtask

  task automatic verify_rows(input logic [ROWS-1:0] a, output logic [DW-1:0] d, output logic e);
    load_addr(a);
    send_cmd(4'h4);
    e = err;
    read_data(d);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] got, d1, d2;
    logic [ROWS-1:0] a;
    logic e;
    int ra, rb;
    void'($urandom(32'd1234));

    repeat (3) @(posedge sclk);
    #1 rst_n = 1;
    @(negedge sclk); #1;
    chk("R1 sdo after reset", DW'(sdo), '0);
    chk("R1 err after reset", DW'(err), '0);

    // R2: shared pins with the port disabled
    sdi = 1; mode = 0; sdo_in = 1; #1;
    chk("R2 usr_in pass", DW'(usr_in), DW'(3'b011));
    chk("R2 usr_clk low phase", DW'(usr_clk), '0);
    chk("R2 sdo_oe off", DW'(sdo_oe), '0);
    @(posedge sclk); #1;
    chk("R2 usr_clk high phase", DW'(usr_clk), DW'(1'b1));
    en_n = 0; sdi = 0; sdo_in = 0; #1;
    chk("R2 usr_clk gated", DW'(usr_clk), '0);
    sdi = 1; mode = 1; sdo_in = 1; #1;
    chk("R2 usr_in gated", DW'(usr_in), '0);
    chk("R2 sdo_oe on", DW'(sdo_oe), DW'(1'b1));
    sdi = 0; mode = 0; sdo_in = 0;
    @(posedge sclk); #1;

    // R8: identifier read-out, least significant bit first
    send_cmd(4'h5);
    shift_io(8, '0, got);
    chk("R8 identifier", got, DW'(8'h0B));

    // R4: data path round trip through both halves
    d1 = rand_word();
    load_data(d1);
    read_data(got);
    chk("R4 data round trip", got, d1);

    // R4: row-select register round trip
    a = '0; a[0] = 1; a[ROWS-1] = 1; a[57] = 1;
    load_addr(a);
    send_cmd(4'h1);
    shift_io(ROWS, '0, got);
    chk("R4 row-select round trip", got, widen(a));

    // R11: unknown code changes neither register
    d1 = rand_word();
    load_data(d1);
    send_cmd(4'hF);
    read_data(got);
    chk("R11 unknown code keeps data", got, d1);

    // R5/R6: random single-row program and verify
    for (int k = 0; k < 8; k++) begin
      ra = $urandom_range(ROWS-1, 0);
      a = '0; a[ra] = 1;
      program_rows(a, rand_word());
      verify_rows(a, got, e);
      chk($sformatf("R5 R6 row %0d readback", ra), got, exp_verify(a));
      chk("R6 err clear after single verify", DW'(e), '0);
    end

    // R5: program two rows at once
    ra = 3; rb = 101;
    a = '0; a[ra] = 1; a[rb] = 1;
    d2 = rand_word();
    program_rows(a, d2);
    a = '0; a[ra] = 1;
    verify_rows(a, got, e);
    chk("R5 first of two rows", got, d2);
    a = '0; a[rb] = 1;
    verify_rows(a, got, e);
    chk("R5 second of two rows", got, d2);

    // R7: multi-row verify gives zeros and sets the error flag
    a = '0; a[ra] = 1; a[rb] = 1;
    verify_rows(a, got, e);
    chk("R7 multi verify data", got, '0);
    chk("R7 multi verify err", DW'(e), DW'(1'b1));
    a = '0; a[ra] = 1;
    verify_rows(a, got, e);
    chk("R7 err cleared by single verify", DW'(e), '0);

    // R6: empty row-select reads zeros without error
    verify_rows('0, got, e);
    chk("R6 empty select data", got, '0);
    chk("R6 empty select err", DW'(e), '0);

    // R9: abort a program before its execute edge
    a = '0; a[ra] = 1;
    load_addr(a);
    load_data(~model[ra]);
    edge_step(1'b1, 1'b0);
    for (int i = 3; i >= 0; i--) edge_step(1'b0, i < 2 ? 1'b1 : 1'b0);
    edge_step(1'b1, 1'b0);
    en_n = 1;
    edge_step(1'b1, 1'b0);
    @(negedge sclk); #1;
    chk("R2 sdo quiet while disabled", DW'(sdo), '0);
    en_n = 0;
    edge_step(1'b0, 1'b0);
    verify_rows(a, got, e);
    chk("R9 aborted program leaves row", got, model[ra]);

    // R10: stored rows survive a port reset
    rst_n = 0;
    @(posedge sclk); #1;
    rst_n = 1;
    chk("R10 err after reset", DW'(err), '0);
    a = '0; a[rb] = 1;
    verify_rows(a, got, e);
    chk("R10 row kept over reset", got, model[rb]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule